// File: doc/BRIEF.md
# Sensor SPI Frame Responder

This block is the sensor side of a full-duplex SPI link. The host always exchanges frames of exactly six bytes (48 bits). While the host shifts a request in, the block shifts a response out. The request carries a one-byte control field and a checksum byte. The response carries a status byte, four payload bytes and a checksum byte. The block checks each request it receives. The message type that a valid request names decides the payload of the next frame, not the current one.

The sensor core provides its measurement words (angular rate, two auxiliary channels, temperature) and two 32-bit configuration words as parallel inputs. Two status inputs report a built-in-test fault and an active commanded test. The commanded-test request from the host is held on an output for the core. The SPI pins are asynchronous to the system clock and pass through a synchronizer first. The response for a frame is frozen in a shadow register when select falls, so inputs that change during a transfer do not alter the bits already committed.

Top module: `sens_spi_responder`

## Requirements
- R1: Frames use SPI mode 0, most significant bit first. MOSI is sampled on the rising SCLK edge, and the next response bit is presented after the falling SCLK edge. Bit 0 of a 48-bit frame is byte 0, bit 7.
- R2: While select is high, the output enable is low, and SCLK and MOSI activity changes no state: frame bit count, message counter and the response are unaffected.
- R3: In request byte 0, bits 2:0 are the next-message code and bit 3 is the commanded-test request. A valid request copies bit 3 to `test_req`.
- R4: Byte 5 of both the request and the response is the bitwise inverse of the 8-bit sum of bytes 0 to 4.
- R5: Response payload by type. Code 0: rate in bytes 1-2 (MSB first) and zeros in bytes 3-4. Codes 1, 2 and 3: rate in bytes 1-2, then aux1, aux2 or temperature in bytes 3-4. Codes 4 and 5: configuration word 1 or 2 in bytes 1-4 (MSB first).
- R6: The code in a valid request sets the type of the next response. Status bits 2:0 carry the type actually sent.
- R7: A request is invalid if the checksum is wrong, the code is 6 or 7, or the clock count is not exactly 48. An invalid request keeps the previous type and test request, and sets status bit 5 in the next response. A valid request clears that bit.
- R8: After reset, the type is 4 (configuration 1), the message counter is 0, the fault bit is 0 and `test_req` is 0.
- R9: Status bits 7:6 hold a 2-bit counter. It increments, wrapping from 3 to 0, after each select period that holds exactly 48 clocks.
- R10: Status bit 4 carries `bit_fault` and bit 3 carries `test_active`, both taken when select falls.
- R11: All 48 response bits are fixed when select falls. Input changes during the transfer do not appear until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Pad drive enable for spi_miso; low means high impedance |
| rate_word | input | 16 | Angular rate sample |
| aux1_word | input | 16 | Auxiliary channel 1 sample |
| aux2_word | input | 16 | Auxiliary channel 2 sample |
| temp_word | input | 16 | Temperature sample |
| cfg1_word | input | 32 | Configuration word 1 |
| cfg2_word | input | 32 | Configuration word 2 |
| bit_fault | input | 1 | Built-in-test fault flag |
| test_active | input | 1 | Commanded test in progress |
| test_req | output | 1 | Commanded-test request from last valid frame |

## Verification
The hardest case to reach is the interaction across frame boundaries. A rejected request must leave the type and test request unchanged, yet raise the fault bit only in the frame after it. Also, length errors of too few and too many clocks must be told apart from checksum errors in how they affect the counter. The stimulus reaches this with sequences of frames in which each frame's response is predicted from a running model of type, counter and fault. Bad checksums, reserved codes, 40-clock and 56-clock frames are placed between valid ones. A rate change forked into the middle of a transfer checks that the shadow register is frozen. SCLK and MOSI toggles with select high, followed by a frame, show that idle activity is ignored.

// File: rtl/sens_spi_pkg.sv
package sens_spi_pkg;

  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 6;
  localparam int FRAME_BITS  = FRAME_BYTES * BYTE_W;
  localparam int BODY_BITS   = (FRAME_BYTES - 1) * BYTE_W;
  localparam int WORD_W      = 16;
  localparam int CFG_W       = 2 * WORD_W;
  localparam int CNT_W       = $clog2(FRAME_BITS + 2);
  localparam int MCNT_W      = 2;

  typedef enum logic [2:0] {
    MSG_RATE = 3'd0,
    MSG_AUX1 = 3'd1,
    MSG_AUX2 = 3'd2,
    MSG_TEMP = 3'd3,
    MSG_CFG1 = 3'd4,
    MSG_CFG2 = 3'd5
  } msg_t;

  // Inverted 8-bit sum of the five bytes ahead of the check byte.
  function automatic logic [BYTE_W-1:0] frame_sum(input logic [BODY_BITS-1:0] body);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < FRAME_BYTES - 1; i++) begin
      acc = acc + body[i*BYTE_W +: BYTE_W];
    end
    return ~acc;
  endfunction

endpackage

// File: rtl/sens_spi_sync.sv
module sens_spi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[b]}};
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d[b]};
      end
    end
    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sens_spi_shift.sv
module sens_spi_shift
  import sens_spi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  cs_n_s,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] resp_frame,
  output logic                  cs_act,
  output logic                  frame_end,
  output logic                  miso_bit,
  output logic [FRAME_BITS-1:0] rx_frame,
  output logic [CNT_W-1:0]      bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                  sclk_prev_q, cs_prev_q, act_q, act_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d, tx_q, tx_d;
  logic                  cs_fall, cs_rise, edge_en, sck_rise, sck_fall;

  assign cs_fall  = cs_prev_q & ~cs_n_s;
  assign cs_rise  = ~cs_prev_q & cs_n_s;
  assign edge_en  = act_q & ~cs_rise;
  assign sck_rise = edge_en & ~sclk_prev_q & sclk_s;
  assign sck_fall = edge_en & sclk_prev_q & ~sclk_s;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (cs_fall) begin
      act_d = 1'b1;
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = resp_frame;
    end else begin
      if (cs_rise) act_d = 1'b0;
      if (sck_rise) begin
        rx_d = {rx_q[FRAME_BITS-2:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall) tx_d = {tx_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
      act_q       <= 1'b0;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_n_s;
      act_q       <= act_d;
      cnt_q       <= cnt_d;
      rx_q        <= rx_d;
      tx_q        <= tx_d;
    end
  end

  assign cs_act    = act_q;
  assign frame_end = act_q & cs_rise;
  assign miso_bit  = tx_q[FRAME_BITS-1];
  assign rx_frame  = rx_q;
  assign bit_cnt   = cnt_q;

  // R2: with select inactive, clock and data activity leave count and shadow alone
  p_idle_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !cs_fall) |=> ($stable(cnt_q) && $stable(tx_q)));

  // R4: the frozen response always sums with its check byte to all ones
  p_resp_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> ((tx_q[47:40] + tx_q[39:32] + tx_q[31:24] + tx_q[23:16]
                  + tx_q[15:8] + tx_q[7:0]) == 8'hFF));

endmodule

// File: rtl/sens_spi_ctrl.sv
module sens_spi_ctrl
  import sens_spi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_end,
  input  logic [FRAME_BITS-1:0] rx_frame,
  input  logic [CNT_W-1:0]      bit_cnt,
  input  logic [WORD_W-1:0]     rate_word,
  input  logic [WORD_W-1:0]     aux1_word,
  input  logic [WORD_W-1:0]     aux2_word,
  input  logic [WORD_W-1:0]     temp_word,
  input  logic [CFG_W-1:0]      cfg1_word,
  input  logic [CFG_W-1:0]      cfg2_word,
  input  logic                  bit_fault,
  input  logic                  test_active,
  output logic [FRAME_BITS-1:0] resp_frame,
  output logic                  test_req
);

  msg_t              type_q, type_d;
  logic [MCNT_W-1:0] mcnt_q, mcnt_d;
  logic              fault_q, fault_d, req_q, req_d;

  logic [BYTE_W-1:0] ctl_byte;
  logic [2:0]        code;
  logic              len_ok, sum_ok, code_ok, req_valid;
  logic [BYTE_W-1:0] status;
  logic [CFG_W-1:0]  payload;

  assign ctl_byte  = rx_frame[FRAME_BITS-1 -: BYTE_W];
  assign code      = ctl_byte[2:0];
  assign len_ok    = (bit_cnt == CNT_W'(FRAME_BITS));
  assign sum_ok    = (frame_sum(rx_frame[FRAME_BITS-1:BYTE_W]) == rx_frame[BYTE_W-1:0]);
  assign code_ok   = (code <= 3'd5);
  assign req_valid = len_ok & sum_ok & code_ok;

  always_comb begin
    type_d  = type_q;
    mcnt_d  = mcnt_q;
    fault_d = fault_q;
    req_d   = req_q;
    if (frame_end) begin
      fault_d = ~req_valid;
      if (req_valid) begin
        type_d = msg_t'(code);
        req_d  = ctl_byte[3];
      end
      if (len_ok) mcnt_d = mcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= MSG_CFG1;
      mcnt_q  <= '0;
      fault_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      type_q  <= type_d;
      mcnt_q  <= mcnt_d;
      fault_q <= fault_d;
      req_q   <= req_d;
    end
  end

  always_comb begin
    case (type_q)
      MSG_RATE: payload = {rate_word, {WORD_W{1'b0}}};
      MSG_AUX1: payload = {rate_word, aux1_word};
      MSG_AUX2: payload = {rate_word, aux2_word};
      MSG_TEMP: payload = {rate_word, temp_word};
      MSG_CFG1: payload = cfg1_word;
      MSG_CFG2: payload = cfg2_word;
      default:  payload = '0;
    endcase
  end

  assign status     = {mcnt_q, fault_q, bit_fault, test_active, type_q};
  assign resp_frame = {status, payload, frame_sum({status, payload})};
  assign test_req   = req_q;

  // R7: type only moves at a frame end, and a length error never moves it
  p_type_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(type_q));
  p_len_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && bit_cnt != CNT_W'(FRAME_BITS)) |=> (fault_q && $stable(type_q) && $stable(mcnt_q)));

  // R9: a full-length frame advances the message counter by one
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && bit_cnt == CNT_W'(FRAME_BITS)) |=> (mcnt_q == $past(mcnt_q) + 2'd1));

endmodule

// File: rtl/sens_spi_responder.sv
module sens_spi_responder
  import sens_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  input  logic [WORD_W-1:0] rate_word,
  input  logic [WORD_W-1:0] aux1_word,
  input  logic [WORD_W-1:0] aux2_word,
  input  logic [WORD_W-1:0] temp_word,
  input  logic [CFG_W-1:0]  cfg1_word,
  input  logic [CFG_W-1:0]  cfg2_word,
  input  logic              bit_fault,
  input  logic              test_active,
  output logic              test_req
);

  logic [1:0]            rst_sync_q;
  logic                  rst_n_s;
  logic [2:0]            pins_s;
  logic                  cs_act, frame_end, miso_bit;
  logic [FRAME_BITS-1:0] rx_frame, resp_frame;
  logic [CNT_W-1:0]      bit_cnt;

  // Asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  sens_spi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    ({spi_sclk, spi_cs_n, spi_mosi}),
    .q    (pins_s)
  );

  sens_spi_shift i_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sclk_s    (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .resp_frame(resp_frame),
    .cs_act    (cs_act),
    .frame_end (frame_end),
    .miso_bit  (miso_bit),
    .rx_frame  (rx_frame),
    .bit_cnt   (bit_cnt)
  );

  sens_spi_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .frame_end  (frame_end),
    .rx_frame   (rx_frame),
    .bit_cnt    (bit_cnt),
    .rate_word  (rate_word),
    .aux1_word  (aux1_word),
    .aux2_word  (aux2_word),
    .temp_word  (temp_word),
    .cfg1_word  (cfg1_word),
    .cfg2_word  (cfg2_word),
    .bit_fault  (bit_fault),
    .test_active(test_active),
    .resp_frame (resp_frame),
    .test_req   (test_req)
  );

  assign spi_miso    = cs_act & miso_bit;
  assign spi_miso_en = cs_act;

  // R8: after reset release the request output starts low
  p_reset_req_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !test_req);

endmodule

// File: tb/test_sens_spi_responder.sv
module test_sens_spi_responder;
  import sens_spi_pkg::*;

  logic clk, rst_n, sclk, cs_n, mosi;
  logic miso, miso_en, test_req;
  logic [15:0] rate_w, aux1_w, aux2_w, temp_w;
  logic [31:0] cfg1_w, cfg2_w;
  logic bf, ta;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model of the block state
  logic [2:0] m_type;
  logic [1:0] m_cnt;
  logic       m_fault, m_req;

  sens_spi_responder i_sens_spi_responder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en),
    .rate_word(rate_w), .aux1_word(aux1_w), .aux2_word(aux2_w), .temp_word(temp_w),
    .cfg1_word(cfg1_w), .cfg2_word(cfg2_w), .bit_fault(bf), .test_active(ta),
    .test_req(test_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] inv_sum(input logic [39:0] b);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 5; i++) s = s + b[i*8 +: 8];
    return ~s;
  endfunction

  function automatic logic [47:0] host_frame(input logic [2:0] code, input logic req, input logic bad);
    logic [39:0] body = {4'h0, req, code, 32'h0};
    logic [7:0]  c    = inv_sum(body);
    if (bad) c = c ^ 8'h01;
    return {body, c};
  endfunction

  function automatic logic [47:0] resp_exp();
    logic [7:0]  st = {m_cnt, m_fault, bf, ta, m_type};
    logic [31:0] pl;
    case (m_type)
      3'd0: pl = {rate_w, 16'h0};
      3'd1: pl = {rate_w, aux1_w};
      3'd2: pl = {rate_w, aux2_w};
      3'd3: pl = {rate_w, temp_w};
      3'd4: pl = cfg1_w;
      default: pl = cfg2_w;
    endcase
    return {st, pl, inv_sum({st, pl})};
  endfunction

  task automatic xfer(input logic [63:0] tx, input int nbits, output logic [63:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[63-i];
      repeat (10) @(negedge clk);
      rx[63-i] = miso;
      sclk = 1'b1;
      repeat (10) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (10) @(negedge clk);
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic run_frame(input logic [2:0] code, input logic req, input logic bad,
                           input int nbits, input string tag);
    logic [63:0] rx, mask, exp;
    logic        ok;
    exp  = {resp_exp(), 16'h0};
    mask = (nbits >= 48) ? {48'hFFFF_FFFF_FFFF, 16'h0} : (~64'h0 << (64 - nbits));
    xfer({host_frame(code, req, bad), 16'h0}, nbits, rx);
    check({tag, " response"}, rx & mask, exp & mask);
    ok = (nbits == 48) && !bad && (code < 3'd6);
    if (nbits == 48) m_cnt = m_cnt + 2'd1;
    if (ok) begin
      m_type = code;
      m_req  = req;
    end
    m_fault = !ok;
    check({tag, " test_req"}, {63'h0, test_req}, {63'h0, m_req});
  endtask

  task automatic t_reset();
    check("R2 R8 enable low after reset", {63'h0, miso_en}, 64'h0);
    check("R8 test_req low after reset", {63'h0, test_req}, 64'h0);
  endtask

  task automatic t_first_frame();
    run_frame(3'd0, 1'b0, 1'b0, 48, "R1 R4 R8 default cfg1");
  endtask

  task automatic t_types();
    run_frame(3'd1, 1'b0, 1'b0, 48, "R5 R6 rate only");
    run_frame(3'd2, 1'b0, 1'b0, 48, "R5 R6 aux1");
    run_frame(3'd3, 1'b0, 1'b0, 48, "R5 R6 aux2");
    run_frame(3'd5, 1'b0, 1'b0, 48, "R5 R6 temp");
    run_frame(3'd4, 1'b0, 1'b0, 48, "R5 R6 cfg2");
    run_frame(3'd0, 1'b0, 1'b0, 48, "R5 R6 cfg1");
  endtask

  task automatic t_bad_checksum();
    run_frame(3'd2, 1'b1, 1'b1, 48, "R4 bad checksum");
    run_frame(3'd2, 1'b0, 1'b0, 48, "R7 fault after bad checksum");
    run_frame(3'd1, 1'b0, 1'b0, 48, "R7 fault cleared");
  endtask

  task automatic t_reserved();
    run_frame(3'd6, 1'b0, 1'b0, 48, "R7 reserved code 6");
    run_frame(3'd7, 1'b0, 1'b0, 48, "R7 reserved code 7");
    run_frame(3'd3, 1'b0, 1'b0, 48, "R7 type kept after reserved");
  endtask

  task automatic t_length();
    run_frame(3'd2, 1'b0, 1'b0, 40, "R7 short frame");
    run_frame(3'd2, 1'b0, 1'b0, 56, "R7 R9 after short frame");
    run_frame(3'd0, 1'b0, 1'b0, 48, "R7 R9 after long frame");
  endtask

  task automatic t_cbit();
    run_frame(3'd0, 1'b1, 1'b0, 48, "R3 request set");
    run_frame(3'd0, 1'b0, 1'b1, 48, "R3 R7 request kept on bad frame");
    run_frame(3'd0, 1'b0, 1'b0, 48, "R3 request cleared");
  endtask

  task automatic t_status_inputs();
    bf = 1'b1; ta = 1'b0;
    run_frame(3'd1, 1'b0, 1'b0, 48, "R10 bit fault");
    bf = 1'b0; ta = 1'b1;
    run_frame(3'd1, 1'b0, 1'b0, 48, "R10 test active");
    ta = 1'b0;
  endtask

  task automatic t_freeze();
    fork
      run_frame(3'd1, 1'b0, 1'b0, 48, "R11 frozen response");
      begin
        repeat (150) @(negedge clk);
        rate_w = 16'hBEEF;
        aux1_w = 16'h0F0F;
      end
    join
    run_frame(3'd0, 1'b0, 1'b0, 48, "R11 new value next frame");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk) sclk = ~sclk;
      mosi = i[0];
      repeat (6) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 enable low while deselected", {63'h0, miso_en}, 64'h0);
    run_frame(3'd0, 1'b0, 1'b0, 48, "R2 idle clocks ignored");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) run_frame(3'd0, 1'b0, 1'b0, 48, "R9 counter wrap");
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    rate_w = 16'h1234; aux1_w = 16'hA5A5; aux2_w = 16'h5A01;
    temp_w = 16'h00C8; cfg1_w = 32'hC0FF_EE01; cfg2_w = 32'h8765_4321;
    bf = 1'b0; ta = 1'b0;
    m_type = 3'd4; m_cnt = 2'd0; m_fault = 1'b0; m_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_first_frame();
    t_types();
    t_bad_checksum();
    t_reserved();
    t_length();
    t_cbit();
    t_status_inputs();
    t_freeze();
    t_idle();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule